// File: doc/BRIEF.md
# GPIO Port with Routed Interrupts

This block is a memory-mapped general-purpose I/O port of up to 32 lines, controlled over a simple 32-bit word register bus. Software sets an output value and a direction per line, and reads back the line levels after a two-flop synchronizer. The pad cells and tristate buffers sit outside: the block hands them an output value and an output enable for each line.

Every line can also raise an interrupt. Two per-line bits pick one of four trigger modes: low level, high level, falling edge or rising edge. A per-line mask bit enables the line. A per-line routing byte steers the line to one of several interrupt output wires, or to none. Lines that share a wire are ORed together. Level triggers hold their wire for as long as the condition lasts. Edge triggers give a single-cycle pulse.

Bus words carry bit 31 as the most significant bit. Transfers are whole words only, so no byte lanes are involved. A register whose bit i controls line i implements only the low `N_LINES` bits.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the line registers read 0, `pin_oe`, `pin_out` and `irq_out` are 0, and every routing byte reads 0xFF.
- R2: Word addresses: line input 0x00, output value 0x04, direction 0x08, interrupt enable 0x0C, polarity 0x10, edge select 0x14, spare 0x18, routing words from 0x20. A read requested in one cycle (`bus_sel`=1, `bus_wr`=0) shows on `bus_rdata` in the next cycle, and the value then holds until the next read. Bits at or above `N_LINES` read 0. Any unassigned address reads 0.
- R3: `pin_out` equals the output value register and `pin_oe` equals the direction register. A 1 in the direction register means the line is driven.
- R4: The line input register shows the pins through a two-flop synchronizer. A read clocked at the second rising edge after the pins change still returns the old value. A read clocked at the third returns the new value.
- R5: With polarity 1 and edge 0, a line triggers on a high level. Its wire rises at the third rising edge after the pin goes high, and stays high while the pin stays high.
- R6: With polarity 0 and edge 0, a line triggers on a low level. The wire stays high for as long as the pin is low.
- R7: With polarity 1 and edge 1, a rising pin produces a high pulse on the routed wire for exactly one cycle.
- R8: With polarity 0 and edge 1, a falling pin produces a single-cycle pulse. A rising pin produces nothing.
- R9: A line whose enable bit is 0 never drives a wire. Clearing the enable bit drops a held level at the next rising edge.
- R10: Routing bytes are packed four to a word at 0x20 + 4*(line/4). Line line%4 occupies bits 8*(line%4)+7 down to 8*(line%4). A byte value k below `N_IRQ` routes the line to `irq_out[k]`. 0xFF, or any value of at least `N_IRQ`, leaves the line unrouted, so it drives no wire.
- R11: Each wire is the OR of all enabled lines routed to it whose trigger condition holds.
- R12: The spare register at 0x18 stores and reads back its line bits, and has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access request for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of a word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| pin_in | input | N_LINES | Line levels from the pads, asynchronous |
| pin_out | output | N_LINES | Value to drive on each line |
| pin_oe | output | N_LINES | Output enable for each line |
| irq_out | output | N_IRQ | Interrupt wires, registered |

## Verification
The bench builds the port with `N_LINES`=8 and `N_IRQ`=3. With these values the routing table spans two words, so the packing across words is checked. A routing byte of 3 is then the smallest out-of-range index and can be tried next to 0xFF. The narrow width also places register bits 8 to 31 above the implemented lines, where they must read 0. Three wires let one wire be shared by two lines while the others carry single level and edge sources, so each of the four trigger modes is seen alone on a wire.

// File: rtl/gpio_irq_pkg.sv
// Package: register word addresses and the "not routed" byte code shared
// by the GPIO port modules and its checker.
package gpio_irq_pkg;
    localparam int BUS_W    = 32;
    localparam int ADDR_W   = 8;
    localparam int ROUTE_W  = 8;

    localparam logic [ADDR_W-1:0] A_PINS    = 8'h00;
    localparam logic [ADDR_W-1:0] A_OUTVAL  = 8'h04;
    localparam logic [ADDR_W-1:0] A_DIR     = 8'h08;
    localparam logic [ADDR_W-1:0] A_ENABLE  = 8'h0C;
    localparam logic [ADDR_W-1:0] A_POL     = 8'h10;
    localparam logic [ADDR_W-1:0] A_EDGE    = 8'h14;
    localparam logic [ADDR_W-1:0] A_SPARE   = 8'h18;
    localparam logic [ADDR_W-1:0] A_ROUTE0  = 8'h20;

    localparam logic [ROUTE_W-1:0] ROUTE_NONE = 8'hFF;
endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchronizer for the asynchronous line inputs.
// Assumes each bit is treated on its own; no multi-bit coherence is implied.
module gpio_irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1;

    // Purpose: shift the raw pins through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1   <= '0;
            sync_out <= '0;
        end else begin
            stage1   <= async_in;
            sync_out <= stage1;
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Register file of the GPIO port: line registers, routing bytes and the
// registered read port. Assumes word-aligned addresses; anything else
// matches no register. Bits above N_LINES are not stored.
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_sel,
    input  logic                              bus_wr,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [BUS_W-1:0]                  bus_wdata,
    output logic [BUS_W-1:0]                  bus_rdata,
    input  logic [N_LINES-1:0]                pins_sync,
    output logic [N_LINES-1:0]                outval_q,
    output logic [N_LINES-1:0]                dir_q,
    output logic [N_LINES-1:0]                enable_q,
    output logic [N_LINES-1:0]                pol_q,
    output logic [N_LINES-1:0]                edge_q,
    output logic [N_LINES-1:0][ROUTE_W-1:0]   route_q
);
    localparam int LINES_PER_WORD = BUS_W / ROUTE_W;
    localparam int ROUTE_WORDS    = (N_LINES + LINES_PER_WORD - 1) / LINES_PER_WORD;

    logic [N_LINES-1:0] spare_q;
    logic               wr_en;
    logic               rd_en;
    logic [BUS_W-1:0]   rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && !bus_wr;

    function automatic logic [BUS_W-1:0] widen(input logic [N_LINES-1:0] v);
        logic [BUS_W-1:0] w;
        w = '0;
        w[N_LINES-1:0] = v;
        return w;
    endfunction

    // Purpose: write the per-line control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outval_q <= '0;
            dir_q    <= '0;
            enable_q <= '0;
            pol_q    <= '0;
            edge_q   <= '0;
            spare_q  <= '0;
        end else if (wr_en) begin
            case (bus_addr)
                A_OUTVAL: outval_q <= bus_wdata[N_LINES-1:0];
                A_DIR:    dir_q    <= bus_wdata[N_LINES-1:0];
                A_ENABLE: enable_q <= bus_wdata[N_LINES-1:0];
                A_POL:    pol_q    <= bus_wdata[N_LINES-1:0];
                A_EDGE:   edge_q   <= bus_wdata[N_LINES-1:0];
                A_SPARE:  spare_q  <= bus_wdata[N_LINES-1:0];
                default: ;
            endcase
        end
    end

    // One routing byte per line, four lines per word.
    for (genvar l = 0; l < N_LINES; l++) begin : g_route
        localparam logic [ADDR_W-1:0] MY_ADDR =
            A_ROUTE0 + ADDR_W'(4 * (l / LINES_PER_WORD));
        localparam int LANE = l % LINES_PER_WORD;

        // Purpose: store this line's routing byte.
        always_ff @(posedge clk) begin
            if (!rst_n)
                route_q[l] <= ROUTE_NONE;
            else if (wr_en && bus_addr == MY_ADDR)
                route_q[l] <= bus_wdata[ROUTE_W*LANE +: ROUTE_W];
        end
    end

    // Purpose: select read data by address.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_PINS:   rd_mux = widen(pins_sync);
            A_OUTVAL: rd_mux = widen(outval_q);
            A_DIR:    rd_mux = widen(dir_q);
            A_ENABLE: rd_mux = widen(enable_q);
            A_POL:    rd_mux = widen(pol_q);
            A_EDGE:   rd_mux = widen(edge_q);
            A_SPARE:  rd_mux = widen(spare_q);
            default: begin
                for (int w = 0; w < ROUTE_WORDS; w++) begin
                    if (bus_addr == A_ROUTE0 + ADDR_W'(4 * w)) begin
                        for (int b = 0; b < LINES_PER_WORD; b++) begin
                            if (w * LINES_PER_WORD + b < N_LINES)
                                rd_mux[ROUTE_W*b +: ROUTE_W] =
                                    route_q[w * LINES_PER_WORD + b];
                            else
                                rd_mux[ROUTE_W*b +: ROUTE_W] = ROUTE_NONE;
                        end
                    end
                end
            end
        endcase
    end

    // Purpose: register read data; hold it between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-line trigger detection. Takes the synchronized pins and keeps their
// previous-cycle copy for edge detection. Output hit[i] is combinational
// and already gated by the line's enable bit.
module gpio_irq_detect #(
    parameter int N_LINES = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] pins_sync,
    input  logic [N_LINES-1:0] enable,
    input  logic [N_LINES-1:0] pol,
    input  logic [N_LINES-1:0] edge_sel,
    output logic [N_LINES-1:0] hit
);
    logic [N_LINES-1:0] pins_prev;

    // Purpose: remember last cycle's synchronized pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pins_prev <= '0;
        else        pins_prev <= pins_sync;
    end

    for (genvar i = 0; i < N_LINES; i++) begin : g_line
        logic lvl_true;
        logic edge_seen;

        // Purpose: evaluate the selected trigger mode for line i.
        always_comb begin
            lvl_true  = pol[i] ? pins_sync[i] : !pins_sync[i];
            edge_seen = pol[i] ? (pins_sync[i] && !pins_prev[i])
                               : (!pins_sync[i] && pins_prev[i]);
            hit[i]    = enable[i] && (edge_sel[i] ? edge_seen : lvl_true);
        end
    end
endmodule

// File: rtl/gpio_irq_route.sv
// Routes per-line hits to the interrupt wires and registers the result.
// Assumes N_IRQ is at most 255, so the "not routed" code never matches.
module gpio_irq_route
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_IRQ   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [N_LINES-1:0]              hit,
    input  logic [N_LINES-1:0][ROUTE_W-1:0] route,
    output logic [N_IRQ-1:0]                irq_out
);
    logic [N_IRQ-1:0] irq_next;

    for (genvar k = 0; k < N_IRQ; k++) begin : g_wire
        // Purpose: OR every line whose routing byte names wire k.
        always_comb begin
            irq_next[k] = 1'b0;
            for (int i = 0; i < N_LINES; i++)
                if (route[i] == ROUTE_W'(k) && hit[i])
                    irq_next[k] = 1'b1;
        end
    end

    // Purpose: register the interrupt wires.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_out <= '0;
        else        irq_out <= irq_next;
    end
endmodule

// File: rtl/gpio_irq_port.sv
// Top of the GPIO port with routed interrupts. Ties the synchronizer,
// register file, trigger detection and routing together. Assumes
// 1 <= N_LINES <= 32 and 1 <= N_IRQ <= 255; pads are external.
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_IRQ   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [7:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [N_LINES-1:0] pin_in,
    output logic [N_LINES-1:0] pin_out,
    output logic [N_LINES-1:0] pin_oe,
    output logic [N_IRQ-1:0]   irq_out
);
    logic [N_LINES-1:0]              pins_sync;
    logic [N_LINES-1:0]              enable_r;
    logic [N_LINES-1:0]              pol_r;
    logic [N_LINES-1:0]              edge_r;
    logic [N_LINES-1:0][ROUTE_W-1:0] route_r;
    logic [N_LINES-1:0]              hit;

    gpio_irq_sync #(.W(N_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pins_sync)
    );

    gpio_irq_regs #(.N_LINES(N_LINES)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pins_sync(pins_sync),
        .outval_q(pin_out), .dir_q(pin_oe),
        .enable_q(enable_r), .pol_q(pol_r), .edge_q(edge_r),
        .route_q(route_r)
    );

    gpio_irq_detect #(.N_LINES(N_LINES)) u_detect (
        .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync),
        .enable(enable_r), .pol(pol_r), .edge_sel(edge_r), .hit(hit)
    );

    gpio_irq_route #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_route (
        .clk(clk), .rst_n(rst_n), .hit(hit), .route(route_r), .irq_out(irq_out)
    );
endmodule

// File: rtl/gpio_irq_port_chk.sv
// Checker for gpio_irq_port, bound into every instance of the top.
// Observes ports plus the enable register; drives nothing.
module gpio_irq_port_chk
    import gpio_irq_pkg::*;
#(
    parameter int N_LINES = 32,
    parameter int N_IRQ   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [7:0]         bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [N_LINES-1:0] pin_in,
    input logic [N_LINES-1:0] pin_out,
    input logic [N_LINES-1:0] pin_oe,
    input logic [N_IRQ-1:0]   irq_out,
    input logic [N_LINES-1:0] enable_r
);
    logic [1:0] since_rst;

    // Purpose: count cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R9
    all_disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_r == '0) |=> (irq_out == '0));

    // R3
    dir_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_DIR) |=> $stable(pin_oe));

    // R3
    outval_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr && bus_addr == A_OUTVAL) |=> $stable(pin_out));

    // R2
    rdata_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));

    // R4
    pin_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && bus_sel && !bus_wr && bus_addr == A_PINS)
        |=> (bus_rdata[N_LINES-1:0] == $past(pin_in, 3)));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_LINES(N_LINES), .N_IRQ(N_IRQ)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out),
    .enable_r(enable_r)
);

// File: tb/gpio_irq_port_test.sv
// Scoreboard bench: driver tasks queue expected items, a monitor process
// pops and compares them against the outputs shortly after each falling edge.
module gpio_irq_port_test;
    localparam int NL = 8;
    localparam int NI = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NL-1:0] pin_in = '0;
    logic [NL-1:0] pin_out;
    logic [NL-1:0] pin_oe;
    logic [NI-1:0] irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;

    typedef struct {
        int          kind;   // 0 rdata, 1 irq_out, 2 pin_out, 3 pin_oe
        string       req;
        logic [31:0] exp;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    gpio_irq_port #(.N_LINES(NL), .N_IRQ(NI)) uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic expect_item(input int kind, input string req, input logic [31:0] exp);
        item_t it;
        it.kind = kind; it.req = req; it.exp = exp;
        sb.push_back(it);
    endtask

    // Monitor: pops every queued item 1 ns after each falling edge.
    always @(negedge clk) begin
        #1;
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = bus_rdata;
                1: act = 32'(irq_out);
                2: act = 32'(pin_out);
                default: act = 32'(pin_oe);
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        expect_item(0, req, exp);
    endtask

    // Write, then check the wires one edge later.
    task automatic write_then_irq(input logic [7:0] a, input logic [31:0] d,
                                  input logic [31:0] exp, input string req);
        bus_write(a, d);
        @(negedge clk);
        expect_item(1, req, exp);
    endtask

    // Change pins, then check the wires at the third following falling edge.
    task automatic pins_then_irq(input logic [NL-1:0] v, input logic [31:0] exp, input string req);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(negedge clk);
        expect_item(1, req, exp);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        expect_item(1, "R1 irq reset", 32'h0);
        expect_item(2, "R1 pin_out reset", 32'h0);
        expect_item(3, "R1 pin_oe reset", 32'h0);
        bus_read(8'h0C, 32'h0, "R1 enable reset");
        bus_read(8'h10, 32'h0, "R1 polarity reset");
        bus_read(8'h20, 32'hFFFF_FFFF, "R1 route word0 reset");
        bus_read(8'h24, 32'hFFFF_FFFF, "R1 route word1 reset");

        // R2 / R3 width and pin drive
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_read(8'h04, 32'h0000_00FF, "R2 upper bits read zero");
        bus_write(8'h08, 32'h0000_000F);
        @(negedge clk);
        expect_item(2, "R3 pin_out value", 32'hFF);
        expect_item(3, "R3 pin_oe direction", 32'h0F);
        bus_read(8'h1C, 32'h0, "R2 unassigned address");
        bus_read(8'h28, 32'h0, "R2 route word past lines");

        // R4 synchronizer latency
        @(negedge clk);
        pin_in = 8'h3C;
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h00;
        @(negedge clk); expect_item(0, "R4 first edge old", 32'h00);
        @(negedge clk); expect_item(0, "R4 second edge old", 32'h00);
        @(negedge clk); expect_item(0, "R4 third edge new", 32'h3C);
        bus_sel = 1'b0;
        pin_in = 8'h00;
        repeat (4) @(negedge clk);

        // Configure: pol lines 0,2,4,5; edge lines 2,3
        bus_write(8'h10, 32'h0000_0035);
        bus_write(8'h14, 32'h0000_000C);
        bus_write(8'h20, 32'h0202_0100);
        bus_write(8'h24, 32'hFF03_0000);
        bus_read(8'h24, 32'hFF03_0000, "R10 route word1 readback");
        @(negedge clk);
        expect_item(1, "R9 all disabled no irq", 32'h0);

        // R10 lines 6,7 low-level true but unrouted (3, 0xFF)
        write_then_irq(8'h0C, 32'h0000_00C0, 32'h0, "R10 unrouted lines silent");
        // R6 line1 low level on wire 1
        write_then_irq(8'h0C, 32'h0000_00FF, 32'h2, "R6 low level asserts");

        // R5 line0 high level on wire 0
        pins_then_irq(8'h01, 32'h3, "R5 high level asserts");
        repeat (3) @(negedge clk);
        expect_item(1, "R5 high level held", 32'h3);
        pins_then_irq(8'h00, 32'h2, "R5 high level released");

        // R7 line2 rising pulse on wire 2
        pins_then_irq(8'h04, 32'h6, "R7 rising pulse");
        @(negedge clk);
        expect_item(1, "R7 pulse one cycle", 32'h2);

        // R8 line3 falling: rise ignored, fall pulses on wire 2
        pins_then_irq(8'h0C, 32'h2, "R8 rise ignored");
        pins_then_irq(8'h04, 32'h6, "R8 falling pulse");
        @(negedge clk);
        expect_item(1, "R8 pulse one cycle", 32'h2);

        // R11 lines 4 and 5 share wire 0
        pins_then_irq(8'h14, 32'h3, "R11 line4 alone");
        pins_then_irq(8'h34, 32'h3, "R11 both lines");
        pins_then_irq(8'h24, 32'h3, "R11 line5 alone");
        pins_then_irq(8'h04, 32'h2, "R11 neither");

        // R6 low level releases when pin rises
        pins_then_irq(8'h06, 32'h0, "R6 low level released");

        // R9 clearing enable drops a held level
        pins_then_irq(8'h07, 32'h1, "R9 line0 level before disable");
        write_then_irq(8'h0C, 32'h0000_00FE, 32'h0, "R9 disable drops level");

        // R12 spare register has no effect
        write_then_irq(8'h18, 32'hFFFF_FFFF, 32'h0, "R12 spare no irq effect");
        expect_item(2, "R12 spare pin_out unchanged", 32'hFF);
        expect_item(3, "R12 spare pin_oe unchanged", 32'h0F);
        bus_read(8'h18, 32'h0000_00FF, "R12 spare readback");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule